// File: doc/BRIEF.md
# Multi-Mode Trigger Output Generator

This block drives one trigger line from the bit clock. Three modes share that line, and only one is active at a time. In divider mode the output is a square wave at the clock rate divided by an integer from 2 to 65535. In block-marker mode a pulse follows each sequence-block start strobe, after a programmable delay and for a programmable width. In wrap-marker mode a pulse of programmable width follows each wrap strobe from the PRBS generator.

Configuration is static-style input: the mode select, the division ratio, the marker delay and the marker width. A change of mode or ratio is held back until the current output period or pulse has completed, so the line never carries a shortened high phase. Output levels, the analog driver and delay modulation are handled elsewhere.

Top module: `trig_gen`

## Requirements
- R1: While `rst_n` is low, `trig_out` is low.
- R2: With `cfg_mode` = 0 (divider) and ratio N, `trig_out` repeats every N cycles: high for floor(N/2) cycles, then low for the remaining N - floor(N/2) cycles. Each period begins with its high phase.
- R3: A `cfg_div` value of 0 or 1 behaves as a ratio of 2.
- R4: A new `cfg_div` value takes effect only at the end of the current divider period. The current high and low phases keep their old lengths.
- R5: With `cfg_mode` = 1 (block marker), a `blk_start` pulse sampled at clock edge e makes `trig_out` high from the cycle D cycles after e, for W cycles. Here D = `cfg_ofs` and W = `cfg_wid`, with W = 0 treated as 1. The delay and width values are captured at edge e.
- R6: A new start strobe that arrives while a delay or pulse is still pending restarts the delay and width from that strobe. The earlier pulse is abandoned.
- R7: With `cfg_mode` = 2 (wrap marker), each `prbs_wrap` pulse produces a pulse of W cycles starting in the first cycle after the strobe edge. `cfg_ofs` has no effect in this mode.
- R8: A strobe that belongs to an inactive mode has no effect. This covers `prbs_wrap` in block-marker mode and `blk_start` in wrap-marker mode.
- R9: A change of `cfg_mode` takes effect only at a boundary. In divider mode the boundary is the end of the low phase. In the marker modes it is an idle cycle with no pulse pending. The change never cuts a high phase short.
- R10: The reserved `cfg_mode` value 3 is ignored, and the current mode keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Mode select: 0 divider, 1 block marker, 2 wrap marker, 3 reserved |
| cfg_div | input | DIV_W | Division ratio |
| cfg_ofs | input | CNT_W | Block-marker delay in cycles |
| cfg_wid | input | CNT_W | Marker width in cycles |
| blk_start | input | 1 | Sequence-block start strobe |
| prbs_wrap | input | 1 | PRBS period wrap strobe |
| trig_out | output | 1 | Trigger line |

## Verification
The hardest situations to reach are configuration writes that land inside a phase. These are a ratio or mode change in the middle of a divider high phase, a mode change while a marker pulse is still high, and a second strobe while a delay or pulse is pending. The bench reaches each one by aligning to a rising edge of `trig_out`. It then counts a fixed number of falling clock edges and writes the new value or fires the strobe at exactly that point. Afterwards it measures the lengths of the high and low runs that follow, and compares them with the lengths the requirements predict.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    MODE_DIV  = 2'd0,
    MODE_BLK  = 2'd1,
    MODE_PRBS = 2'd2,
    MODE_RSVD = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_WAIT  = 2'd1,
    PS_PULSE = 2'd2
  } pulse_st_e;
endpackage

// File: rtl/trig_divider.sv
module trig_divider
  import trig_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  output logic             wave_o,
  output logic             end_o
);
  localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] n_q, n_d;
  logic [DIV_W-1:0] n_load;
  logic [DIV_W-1:0] half;
  logic             last;

  assign n_load = (cfg_div_i < MIN_RATIO) ? MIN_RATIO : cfg_div_i;
  assign half   = n_q >> 1;
  assign last   = (cnt_q == n_q - 1'b1);
  assign end_o  = en_i && last;
  assign wave_o = (cnt_q < half);

  always_comb begin
    cnt_d = cnt_q;
    n_d   = n_q;
    if (start_i || (en_i && last)) begin
      cnt_d = '0;
      n_d   = n_load;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= MIN_RATIO;
    end else begin
      cnt_q <= cnt_d;
      n_q   <= n_d;
    end
  end

  a_r3_min_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    n_q >= MIN_RATIO);
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_q < n_q);
endmodule

// File: rtl/trig_pulse.sv
module trig_pulse
  import trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] wid_i,
  output logic             pulse_o,
  output logic             idle_o
);
  pulse_st_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic [CNT_W-1:0] wid_eff;

  assign wid_eff = (wid_i == '0) ? CNT_W'(1) : wid_i;
  assign pulse_o = (state_q == PS_PULSE);
  assign idle_o  = (state_q == PS_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wid_d   = wid_q;
    if (go_i) begin
      wid_d = wid_eff;
      if (ofs_i == '0) begin
        state_d = PS_PULSE;
        cnt_d   = wid_eff - 1'b1;
      end else begin
        state_d = PS_WAIT;
        cnt_d   = ofs_i - 1'b1;
      end
    end else begin
      case (state_q)
        PS_WAIT: begin
          if (cnt_q == '0) begin
            state_d = PS_PULSE;
            cnt_d   = wid_q - 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PS_PULSE: begin
          if (cnt_q == '0) state_d = PS_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      wid_q   <= CNT_W'(1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wid_q   <= wid_d;
    end
  end

  // R5: an expired delay always turns into a pulse
  a_r5_wait_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAIT && cnt_q == '0 && !go_i) |=> pulse_o);
  // R5: a pulse only ends once its width has run out
  a_r5_fall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_o) && !$past(go_i)) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/trig_mode_ctl.sv
module trig_mode_ctl
  import trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode_i,
  input  logic       div_end_i,
  input  logic       pulse_idle_i,
  input  logic       go_i,
  output trig_mode_e mode_o,
  output logic       enter_div_o
);
  trig_mode_e mode_q, mode_d;
  trig_mode_e req;
  logic       bound;
  logic       sw;

  assign req   = trig_mode_e'(cfg_mode_i);
  assign bound = (mode_q == MODE_DIV) ? div_end_i : (pulse_idle_i && !go_i);
  assign sw    = bound && (req != MODE_RSVD) && (req != mode_q);

  always_comb begin
    mode_d = mode_q;
    if (sw) mode_d = req;
  end

  assign enter_div_o = sw && (req == MODE_DIV);
  assign mode_o      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BLK;
    else        mode_q <= mode_d;
  end

  a_r9_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(bound));
  a_r10_reserved_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode_i == 2'd3) |=> mode_q == $past(mode_q));
endmodule

// File: rtl/trig_gen.sv
module trig_gen
  import trig_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_ofs,
  input  logic [CNT_W-1:0] cfg_wid,
  input  logic             blk_start,
  input  logic             prbs_wrap,
  output logic             trig_out
);
  trig_mode_e       mode_act;
  logic             enter_div;
  logic             div_wave;
  logic             div_end;
  logic             pulse_on;
  logic             pulse_idle;
  logic             go;
  logic [CNT_W-1:0] ofs_sel;

  assign go = ((mode_act == MODE_BLK)  && blk_start) ||
              ((mode_act == MODE_PRBS) && prbs_wrap);
  assign ofs_sel = (mode_act == MODE_BLK) ? cfg_ofs : '0;

  trig_mode_ctl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode_i   (cfg_mode),
    .div_end_i    (div_end),
    .pulse_idle_i (pulse_idle),
    .go_i         (go),
    .mode_o       (mode_act),
    .enter_div_o  (enter_div)
  );

  trig_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (mode_act == MODE_DIV),
    .start_i   (enter_div),
    .cfg_div_i (cfg_div),
    .wave_o    (div_wave),
    .end_o     (div_end)
  );

  trig_pulse #(.CNT_W(CNT_W)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .ofs_i   (ofs_sel),
    .wid_i   (cfg_wid),
    .pulse_o (pulse_on),
    .idle_o  (pulse_idle)
  );

  assign trig_out = (mode_act == MODE_DIV) ? div_wave : pulse_on;

  a_r9_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act != $past(mode_act)) |-> !$past(trig_out));
  a_r8_marker_idle_in_div: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == MODE_DIV) |-> pulse_idle);
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> !trig_out);
endmodule

// File: tb/tb_trig_gen.sv
module tb_trig_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_div;
  logic [15:0] cfg_ofs;
  logic [15:0] cfg_wid;
  logic        blk_start;
  logic        prbs_wrap;
  logic        trig_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
    .cfg_ofs(cfg_ofs), .cfg_wid(cfg_wid), .blk_start(blk_start),
    .prbs_wrap(prbs_wrap), .trig_out(trig_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input bit val, input int limit, output int n);
    n = 0;
    while (trig_out === val && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    int x;
    run_len(1'b1, 5000, x);
    run_len(1'b0, 5000, x);
  endtask

  task automatic strobe(input int src, input bit v);
    if (src == 0) blk_start = v;
    else          prbs_wrap = v;
  endtask

  task automatic test_div(input string tag, input int n, input int eff);
    int h, l;
    cfg_div = 16'(n);
    wait_rise();
    wait_rise();
    run_len(1'b1, 5000, h);
    run_len(1'b0, 5000, l);
    check({tag, " high"}, h, eff / 2);
    check({tag, " low"}, l, eff - eff / 2);
  endtask

  // d/w: expected delay and width; r: index of a second strobe (-1 none)
  task automatic pulse_case(input string tag, input int src, input int d,
                            input int w, input int r, input bit none);
    int bad = 0;
    int fa = 0, fe = 0;
    strobe(src, 1'b1);
    @(negedge clk);
    strobe(src, 1'b0);
    for (int i = 0; i < 40; i++) begin
      int e;
      int b;
      b = (r >= 0 && i > r) ? r + 1 : 0;
      e = (i >= b + d && i < b + d + w) ? 1 : 0;
      if (none) e = 0;
      if (int'(trig_out) != e) begin
        if (bad == 0) begin fa = int'(trig_out); fe = e; end
        bad++;
      end
      strobe(src, (i == r));
      @(negedge clk);
    end
    strobe(src, 1'b0);
    check(tag, fa, fe);
  endtask

  initial begin
    int h, l;
    rst_n = 1'b0; cfg_mode = 2'd0; cfg_div = 16'd2;
    cfg_ofs = '0; cfg_wid = 16'd1; blk_start = 1'b0; prbs_wrap = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset low", int'(trig_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 divider ratios
    test_div("R2 n2", 2, 2);
    test_div("R2 n3", 3, 3);
    test_div("R2 n10", 10, 10);
    test_div("R2 n7", 7, 7);
    test_div("R2 n1001", 1001, 1001);
    // R3 clamp
    test_div("R3 n0", 0, 2);
    test_div("R3 n1", 1, 2);

    // R4 deferred ratio change
    cfg_div = 16'd20;
    wait_rise(); wait_rise();
    @(negedge clk); @(negedge clk);
    cfg_div = 16'd6;
    run_len(1'b1, 5000, h);
    check("R4 old high kept", h, 8);
    run_len(1'b0, 5000, l);
    check("R4 old low kept", l, 10);
    run_len(1'b1, 5000, h);
    check("R4 new high", h, 3);
    run_len(1'b0, 5000, l);
    check("R4 new low", l, 3);

    // R10 reserved mode ignored
    cfg_div = 16'd4;
    wait_rise();
    cfg_mode = 2'd3;
    repeat (20) @(negedge clk);
    wait_rise();
    run_len(1'b1, 5000, h);
    run_len(1'b0, 5000, l);
    check("R10 still divider high", h, 2);
    check("R10 still divider low", l, 2);

    // R9 divider -> block marker mid high phase
    cfg_mode = 2'd0; cfg_div = 16'd12;
    wait_rise(); wait_rise();
    @(negedge clk); @(negedge clk);
    cfg_mode = 2'd1;
    run_len(1'b1, 5000, h);
    check("R9 high not cut", h, 4);
    run_len(1'b0, 40, l);
    check("R9 idle after switch", l, 40);

    // R5 block marker delay and width
    pulse_case("R5 d0 w1", 0, 0, 1, -1, 1'b0);
    cfg_ofs = 16'd3; cfg_wid = 16'd4;
    pulse_case("R5 d3 w4", 0, 3, 4, -1, 1'b0);
    cfg_ofs = 16'd5; cfg_wid = 16'd0;
    pulse_case("R5 width0 as 1", 0, 5, 1, -1, 1'b0);
    cfg_ofs = 16'd0; cfg_wid = 16'd6;
    pulse_case("R5 d0 w6", 0, 0, 6, -1, 1'b0);
    // R6 retrigger during pulse and during delay
    cfg_ofs = 16'd2; cfg_wid = 16'd5;
    pulse_case("R6 restart in pulse", 0, 2, 5, 3, 1'b0);
    cfg_ofs = 16'd4; cfg_wid = 16'd2;
    pulse_case("R6 restart in delay", 0, 4, 2, 1, 1'b0);
    // R8 wrap strobe ignored in block mode
    pulse_case("R8 wrap in block mode", 1, 0, 1, -1, 1'b1);

    // R7 wrap marker, offset ignored
    cfg_mode = 2'd2; cfg_ofs = 16'd7; cfg_wid = 16'd3;
    repeat (4) @(negedge clk);
    pulse_case("R7 wrap pulse", 1, 0, 3, -1, 1'b0);
    // R8 block strobe ignored in wrap mode
    pulse_case("R8 block in wrap mode", 0, 0, 1, -1, 1'b1);

    // R9 wrap marker -> divider while pulse is high
    cfg_wid = 16'd8;
    prbs_wrap = 1'b1;
    @(negedge clk);
    prbs_wrap = 1'b0;
    @(negedge clk); @(negedge clk);
    cfg_mode = 2'd0; cfg_div = 16'd4;
    run_len(1'b1, 5000, h);
    check("R9 pulse not cut", h, 6);
    run_len(1'b0, 5000, l);
    check("R9 one idle cycle", l, 1);
    run_len(1'b1, 5000, h);
    check("R9 divider starts high", h, 2);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual %0d expected done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule